// File: doc/BRIEF.md
# Translation Cache Control and Way Replacement

This block sits beside a 4-way, 32-set address-translation cache. It holds the cache's control word and the valid flag of every entry. It also chooses which way the next refill goes into. The control word carries five fields:

- a translation enable;
- an index-hash select;
- a self-clearing invalidate-all command;
- a single/multiple address-space mode;
- a 2-bit way-replacement counter.

For each lookup, the block turns the virtual address and the address-space identifier into a set number. It reports the valid flags of that set, so the exception logic and the refill handler can act on them.

The replacement counter is driven mainly by translation exceptions. On a miss it points at the first empty way of the indexed set, searching from way 0 upward. If the set is already full, it steps on to the next way. On any other translation fault it takes the number of the way that faulted. Software may write the counter directly, but an exception in the same cycle wins. A refill strobe marks the way named by the counter as valid in the indexed set.

Top module: `tlb_ctl`

## Requirements
- R1: After reset the following are all zero: every valid flag, every control field, `reg_rdata`, `way_valid` and `repl_way`.
- R2: A register write sets these fields, which read back on `reg_rdata` the cycle after the write:
  - the enable at bit 0, also driven on `xlat_en`;
  - the hash select at bit 1;
  - the counter at bits 5:4;
  - the address-space mode at bit 8, also driven on `single_space`.
- R3: Bit 2 is the invalidate command and always reads 0. Every bit other than 0, 1, 2, 4, 5 and 8 reads 0 whatever was written.
- R4: With the hash select at 0, `set_idx` equals `lkp_va[16:12]`. With it at 1, `set_idx` equals `lkp_va[16:12]` XOR `lkp_asid[4:0]`. The index is combinational from the lookup inputs.
- R5: `entry_wr` sets the valid flag of way `repl_way` in set `set_idx`. `way_valid[w]` shows way w of the current `set_idx`, and the new flag is visible from the next cycle.
- R6: Writing 1 to bit 2 clears every valid flag in every set. If `entry_wr` arrives in the same cycle, that flag stays cleared.
- R7: On `miss_evt` with at least one flag of `way_valid` clear, the counter becomes the lowest-numbered clear way.
- R8: On `miss_evt` with all four flags set, the counter advances by one, wrapping from 3 to 0.
- R9: On `fault_evt` without `miss_evt`, the counter becomes `fault_way`.
- R10: A counter update from `miss_evt` or `fault_evt` overrides a software write of bits 5:4 in the same cycle. The other fields of that write still take effect.
- R11: When `miss_evt` and `fault_evt` arrive together, the miss rule is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| lkp_va | input | 32 | Lookup virtual address |
| lkp_asid | input | 8 | Lookup address-space identifier |
| set_idx | output | 5 | Set number for the lookup |
| way_valid | output | 4 | Valid flags of the indexed set |
| repl_way | output | 2 | Replacement counter |
| xlat_en | output | 1 | Translation enable |
| single_space | output | 1 | Single address-space mode |
| miss_evt | input | 1 | Translation miss exception |
| fault_evt | input | 1 | Other translation exception |
| fault_way | input | 2 | Way that caused a non-miss exception |
| entry_wr | input | 1 | Refill strobe: mark way `repl_way` valid |

## Verification
The hardest state to reach is a full set whose flags were filled through the counter itself. Valid flags can only be set through `entry_wr` at whatever way the counter points to. So the stimulus first parks the counter with software writes, then refills the same index once per way, and only after that raises a miss.

The same-cycle collisions are driven on purpose, not left to chance:
- a miss or fault together with a counter write;
- a miss together with a fault;
- an invalidate together with a refill.

A long random phase with rare invalidates then lets sets fill and drain against the bench model.

// File: rtl/tlb_ctl_pkg.sv
package tlb_ctl_pkg;
   localparam int REG_W   = 32;
   localparam int EN_BIT  = 0;
   localparam int HSH_BIT = 1;
   localparam int INV_BIT = 2;
   localparam int CTR_LO  = 4;
   localparam int CTR_W   = 2;
   localparam int SAS_BIT = 8;
endpackage

// File: rtl/tlb_set_index.sv
module tlb_set_index #(
   parameter int VA_W       = 32,
   parameter int ASID_W     = 8,
   parameter int IDX_W      = 5,
   parameter int PAGE_SHIFT = 12,
   parameter bit HASH_EN    = 1'b1
) (
   input  logic [VA_W-1:0]   va,
   input  logic [ASID_W-1:0] asid,
   input  logic              hash_sel,
   output logic [IDX_W-1:0]  idx
);
   logic [IDX_W-1:0] vpn_bits;
   assign vpn_bits = va[PAGE_SHIFT +: IDX_W];

   if (PAGE_SHIFT + IDX_W > VA_W) begin : g_bad_va
      $error("tlb_set_index: index bits exceed address width");
   end

   if (HASH_EN) begin : g_hash
      if (ASID_W < IDX_W) begin : g_bad_asid
         $error("tlb_set_index: identifier narrower than index");
      end
      assign idx = hash_sel ? (vpn_bits ^ asid[IDX_W-1:0]) : vpn_bits;
   end else begin : g_plain
      logic unused_ok;
      assign unused_ok = hash_sel ^ (^asid);
      assign idx = vpn_bits;
   end
endmodule

// File: rtl/tlb_valid_array.sv
module tlb_valid_array #(
   parameter int SETS = 32,
   parameter int WAYS = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_sel,
   input  logic [WAY_W-1:0] way_sel,
   input  logic [IDX_W-1:0] rd_sel,
   output logic [WAYS-1:0]  rd_flags
);
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("tlb_valid_array: SETS must be a power of two");
   end

   logic [WAYS-1:0] rows [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [WAYS-1:0] flags_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr_all) begin
            flags_q <= '0;
         end else if (set_en && set_sel == IDX_W'(s)) begin
            flags_q[way_sel] <= 1'b1;
         end
      end
      assign rows[s] = flags_q;
   end

   assign rd_flags = rows[rd_sel];
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss,
   input  logic             fault,
   input  logic [WAY_W-1:0] fault_way,
   input  logic [WAYS-1:0]  set_flags,
   input  logic             sw_we,
   input  logic [WAY_W-1:0] sw_val,
   output logic [WAY_W-1:0] ctr
);
   logic [WAY_W-1:0] ctr_q, ctr_d, first_free;

   always_comb begin
      first_free = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!set_flags[w]) first_free = WAY_W'(w);
      end
   end

   always_comb begin
      if (miss)       ctr_d = (&set_flags) ? WAY_W'(ctr_q + 1'b1) : first_free;
      else if (fault) ctr_d = fault_way;
      else if (sw_we) ctr_d = sw_val;
      else            ctr_d = ctr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctr_q <= '0;
      else        ctr_q <= ctr_d;
   end

   assign ctr = ctr_q;
endmodule

// File: rtl/tlb_ctl.sv
module tlb_ctl
   import tlb_ctl_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int ASID_W     = 8,
   parameter int SETS       = 32,
   parameter int WAYS       = 4,
   parameter int PAGE_SHIFT = 12,
   parameter bit HASH_EN    = 1'b1,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [VA_W-1:0]   lkp_va,
   input  logic [ASID_W-1:0] lkp_asid,
   output logic [IDX_W-1:0]  set_idx,
   output logic [WAYS-1:0]   way_valid,
   output logic [WAY_W-1:0]  repl_way,
   output logic              xlat_en,
   output logic              single_space,
   input  logic              miss_evt,
   input  logic              fault_evt,
   input  logic [WAY_W-1:0]  fault_way,
   input  logic              entry_wr
);
   if (WAYS < 2 || (1 << WAY_W) != WAYS || WAY_W > CTR_W) begin : g_bad_ways
      $error("tlb_ctl: WAYS must be a power of two fitting the counter field");
   end

   logic en_q, hsh_q, sas_q, inv_cmd;

   assign inv_cmd = reg_we & reg_wdata[INV_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         hsh_q <= 1'b0;
         sas_q <= 1'b0;
      end else if (reg_we) begin
         en_q  <= reg_wdata[EN_BIT];
         hsh_q <= reg_wdata[HSH_BIT];
         sas_q <= reg_wdata[SAS_BIT];
      end
   end

   tlb_set_index #(
      .VA_W(VA_W), .ASID_W(ASID_W), .IDX_W(IDX_W),
      .PAGE_SHIFT(PAGE_SHIFT), .HASH_EN(HASH_EN)
   ) u_idx (
      .va(lkp_va), .asid(lkp_asid), .hash_sel(hsh_q), .idx(set_idx)
   );

   tlb_valid_array #(.SETS(SETS), .WAYS(WAYS)) u_vld (
      .clk(clk), .rst_n(rst_n), .clr_all(inv_cmd), .set_en(entry_wr),
      .set_sel(set_idx), .way_sel(repl_way), .rd_sel(set_idx),
      .rd_flags(way_valid)
   );

   tlb_repl_ctr #(.WAYS(WAYS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .miss(miss_evt), .fault(fault_evt),
      .fault_way(fault_way), .set_flags(way_valid), .sw_we(reg_we),
      .sw_val(reg_wdata[CTR_LO +: WAY_W]), .ctr(repl_way)
   );

   always_comb begin
      reg_rdata                   = '0;
      reg_rdata[EN_BIT]           = en_q;
      reg_rdata[HSH_BIT]          = hsh_q;
      reg_rdata[CTR_LO +: WAY_W]  = repl_way;
      reg_rdata[SAS_BIT]          = sas_q;
   end

   assign xlat_en      = en_q;
   assign single_space = sas_q;
endmodule

// File: rtl/tlb_ctl_chk.sv
module tlb_ctl_chk #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [31:0]      reg_wdata,
   input logic             miss_evt,
   input logic             fault_evt,
   input logic [WAY_W-1:0] fault_way,
   input logic [WAYS-1:0]  way_valid,
   input logic [WAY_W-1:0] repl_way
);
   a_r6_invalidate_all: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_wdata[2]) |=> (way_valid == '0));

   a_r7_way0_first: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_evt && !way_valid[0]) |=> (repl_way == '0));

   a_r8_full_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_evt && (&way_valid)) |=> (repl_way == WAY_W'($past(repl_way) + 1'b1)));

   a_r9_fault_load: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_evt && !miss_evt) |=> (repl_way == $past(fault_way)));

   a_r10_hw_beats_sw: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_evt && !miss_evt && reg_we) |=> (repl_way == $past(fault_way)));
endmodule

bind tlb_ctl tlb_ctl_chk #(.WAYS(WAYS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
   .miss_evt(miss_evt), .fault_evt(fault_evt), .fault_way(fault_way),
   .way_valid(way_valid), .repl_way(repl_way)
);

// File: tb/tb_tlb_ctl.sv
module tb_tlb_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] lkp_va = '0;
   logic [7:0]  lkp_asid = '0;
   logic [4:0]  set_idx;
   logic [3:0]  way_valid;
   logic [1:0]  repl_way;
   logic        xlat_en, single_space;
   logic        miss_evt = 1'b0, fault_evt = 1'b0, entry_wr = 1'b0;
   logic [1:0]  fault_way = '0;

   int compared = 0;
   int mismatched = 0;

   logic [3:0] m_v [32];
   logic       m_en, m_hsh, m_sas;
   logic [1:0] m_ctr;

   always #5 clk = ~clk;

   tlb_ctl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .lkp_va(lkp_va), .lkp_asid(lkp_asid),
      .set_idx(set_idx), .way_valid(way_valid), .repl_way(repl_way),
      .xlat_en(xlat_en), .single_space(single_space), .miss_evt(miss_evt),
      .fault_evt(fault_evt), .fault_way(fault_way), .entry_wr(entry_wr)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // One cycle: drive at negedge, compare against model, advance model.
   task automatic step(string tag, bit we, logic [31:0] wd, logic [31:0] va,
                       logic [7:0] asid, bit ms, bit ft, logic [1:0] fw, bit ew);
      int idx, first;
      logic [3:0] fl;
      @(negedge clk);
      reg_we = we; reg_wdata = wd; lkp_va = va; lkp_asid = asid;
      miss_evt = ms; fault_evt = ft; fault_way = fw; entry_wr = ew;
      #1;
      idx = m_hsh ? int'(va[16:12] ^ asid[4:0]) : int'(va[16:12]);
      fl  = m_v[idx];
      chk({tag, "/R2"}, "rdata", reg_rdata,
          {23'd0, m_sas, 2'd0, m_ctr, 2'd0, m_hsh, m_en});
      chk({tag, "/R2"}, "xlat_en", 32'(xlat_en), 32'(m_en));
      chk({tag, "/R2"}, "single_space", 32'(single_space), 32'(m_sas));
      chk({tag, "/R4"}, "set_idx", 32'(set_idx), 32'(idx));
      chk({tag, "/R5"}, "way_valid", 32'(way_valid), 32'(fl));
      chk({tag, "/R7"}, "repl_way", 32'(repl_way), 32'(m_ctr));
      // next state
      if (we && wd[2]) begin
         for (int s = 0; s < 32; s++) m_v[s] = '0;
      end else if (ew) begin
         m_v[idx][m_ctr] = 1'b1;
      end
      first = 0;
      for (int w = 3; w >= 0; w--) if (!fl[w]) first = w;
      if (ms)      m_ctr = (fl == 4'hF) ? m_ctr + 2'd1 : 2'(first);
      else if (ft) m_ctr = fw;
      else if (we) m_ctr = wd[5:4];
      if (we) begin
         m_en = wd[0]; m_hsh = wd[1]; m_sas = wd[8];
      end
   endtask

   task automatic idle(string tag, logic [31:0] va, logic [7:0] asid);
      step(tag, 0, '0, va, asid, 0, 0, 2'd0, 0);
   endtask

   task automatic set_ctr(string tag, logic [1:0] c);
      step(tag, 1, {26'd0, c, 4'd0}, '0, '0, 0, 0, 2'd0, 0);
   endtask

   initial begin : watchdog
      #1_000_000;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : main
      for (int s = 0; s < 32; s++) m_v[s] = '0;
      m_en = 0; m_hsh = 0; m_sas = 0; m_ctr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      idle("R1", 32'h0001_F000, 8'h00);
      // R2 / R3: all-ones write, only live fields read back
      step("R3", 1, 32'hFFFF_FFFF, '0, '0, 0, 0, 2'd0, 0);
      idle("R3", '0, '0);
      step("R2", 1, 32'h0000_0000, '0, '0, 0, 0, 2'd0, 0);
      idle("R2", '0, '0);
      step("R2", 1, 32'h0000_0121, '0, '0, 0, 0, 2'd0, 0);
      idle("R2", '0, '0);
      // R4: direct and hashed index
      step("R4", 1, 32'h0, '0, '0, 0, 0, 2'd0, 0);
      idle("R4", 32'h0001_5000, 8'h0F);
      idle("R4", 32'hABCD_A000, 8'h1F);
      step("R4", 1, 32'h2, '0, '0, 0, 0, 2'd0, 0);
      idle("R4", 32'h0001_5000, 8'h0F);
      idle("R4", 32'hABCD_A000, 8'hE3);
      step("R4", 1, 32'h0, '0, '0, 0, 0, 2'd0, 0);
      // R5: fill ways 0 and 1 of set 3
      set_ctr("R5", 2'd0);
      step("R5", 0, '0, 32'h0000_3000, '0, 0, 0, 2'd0, 1);
      set_ctr("R5", 2'd1);
      step("R5", 0, '0, 32'h0000_3000, '0, 0, 0, 2'd0, 1);
      idle("R5", 32'h0000_3000, '0);
      // R7: miss with ways 2,3 empty -> 2; empty set -> 0
      step("R7", 0, '0, 32'h0000_3000, '0, 1, 0, 2'd0, 0);
      idle("R7", 32'h0000_3000, '0);
      step("R7", 0, '0, 32'h0000_4000, '0, 1, 0, 2'd0, 0);
      idle("R7", '0, '0);
      // fill ways 2,3 of set 3
      set_ctr("R5", 2'd2);
      step("R5", 0, '0, 32'h0000_3000, '0, 0, 0, 2'd0, 1);
      set_ctr("R5", 2'd3);
      step("R5", 0, '0, 32'h0000_3000, '0, 0, 0, 2'd0, 1);
      // R8: full set, counter 3 wraps to 0, then 0 -> 1
      step("R8", 0, '0, 32'h0000_3000, '0, 1, 0, 2'd0, 0);
      step("R8", 0, '0, 32'h0000_3000, '0, 1, 0, 2'd0, 0);
      idle("R8", 32'h0000_3000, '0);
      // R9: fault load
      step("R9", 0, '0, '0, '0, 0, 1, 2'd2, 0);
      step("R9", 0, '0, '0, '0, 0, 1, 2'd1, 0);
      idle("R9", '0, '0);
      // R10: fault and miss beat software counter write; other fields land
      step("R10", 1, 32'h0000_0131, '0, '0, 0, 1, 2'd2, 0);
      idle("R10", '0, '0);
      step("R10", 1, 32'h0000_0030, 32'h0000_3000, '0, 1, 0, 2'd0, 0);
      idle("R10", 32'h0000_3000, '0);
      // R11: miss and fault together, miss rule wins
      step("R11", 0, '0, 32'h0000_7000, '0, 1, 1, 2'd3, 0);
      idle("R11", '0, '0);
      // R6: invalidate together with refill
      set_ctr("R6", 2'd1);
      step("R6", 0, '0, 32'h0000_9000, '0, 0, 0, 2'd0, 1);
      step("R6", 1, 32'h0000_0004, 32'h0000_9000, '0, 0, 0, 2'd0, 1);
      idle("R6", 32'h0000_9000, '0);
      idle("R6", 32'h0000_3000, '0);
      // random phase
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] wd;
         bit we;
         we = ($urandom % 8) == 0;
         wd = $urandom & 32'hFFFF_FFFB;
         if (($urandom % 6) == 0) wd[2] = 1'b1;
         step("RND", we, wd, {15'd0, 3'($urandom), 14'($urandom)}, 8'($urandom),
              ($urandom % 5) == 0, ($urandom % 7) == 0, 2'($urandom),
              ($urandom % 3) == 0);
      end
      idle("END", '0, '0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule